// File: doc/BRIEF.md
# Saturating Integer Result Clamp

This stage sits at the end of an integer element datapath. The arithmetic before it works at the larger of the source and destination element widths and passes on a two's-complement result one bit wider than the widest lane (64 data bits plus a guard bit). The stage narrows that value to the destination element width selected per element (8, 16, 32 or 64 bits).

When saturation is enabled, values outside the destination range are pinned to the nearest bound. The bounds are signed or unsigned depending on a per-element sign select. When saturation is off, the value wraps to the destination width instead.

The narrowed value leaves the stage extended to 64 bits: sign-extended for signed operation and zero-extended otherwise. Alongside it the stage produces a per-element overflow flag for the element's condition field, set only when a clamp actually happened. It also raises an illegal-operation indication when saturation is asked for on an operation that also wants overflow-enable semantics. The stage holds no summary or sticky state. It has one register stage with a valid qualifier.

Top module: `sat_clamp_stage`

## Requirements
- R1: With saturation on and in_signed=0, a wide value above 2^w-1 becomes 2^w-1 and a negative wide value becomes 0, zero-extended to 64 bits (w = destination width).
- R2: With saturation on and in_signed=1, a wide value above 2^(w-1)-1 becomes 2^(w-1)-1 and one below -2^(w-1) becomes -2^(w-1), sign-extended to 64 bits.
- R3: With saturation on, a wide value already inside the selected range leaves unchanged, extended per in_signed, with out_ov=0.
- R4: in_ewidth code 0, 1, 2, 3 selects a destination width of 8, 16, 32, 64 bits respectively.
- R5: out_ov is 1 exactly when in_rc=1, saturation is on and the element was clamped; it depends only on the current element, never on earlier ones.
- R6: With saturation off, the result is the low w bits of the wide value, sign-extended when in_signed=1 and zero-extended otherwise, and out_ov=0.
- R7: out_illegal is 1 exactly when saturation is on and in_oe=1, whatever in_rc is; the clamped result is still produced.
- R8: Outputs appear one clock after an accepted input; out_valid follows in_valid with one cycle delay, and when in_valid=0 the result and flags keep their previous values.
- R9: While rst_n is low at a clock edge, all outputs are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input element present |
| in_wide | input | 65 | Wide two's-complement result with guard bit |
| in_ewidth | input | 2 | Destination width code (0:8, 1:16, 2:32, 3:64) |
| in_signed | input | 1 | 1 = signed range, 0 = unsigned range |
| in_sat_en | input | 1 | Saturation enable |
| in_rc | input | 1 | Condition field write requested |
| in_oe | input | 1 | Overflow-enable form of the operation |
| out_valid | output | 1 | Registered result present |
| out_res | output | 64 | Narrowed result, extended to 64 bits |
| out_ov | output | 1 | Per-element saturation flag for the condition field |
| out_illegal | output | 1 | Saturation combined with overflow-enable |

## Verification
The bench drives values just beyond each bound, exactly on each bound, and well past it at every destination width. This separates off-by-one bound errors and lane mix-ups from a correct clamp. Negative inputs under unsigned mode and the most extreme 65-bit values at the 64-bit width check the guard bit, which is the only thing that tells a large positive value from a negative one. Runs with saturation off, in_rc low and in_oe high, plus a saturating element followed by a clean one, confirm that wrap, the overflow flag and the illegal flag are each gated only by their own controls and carry nothing between elements. Random elements across all widths and modes then compare against a behavioural model every clock.

// File: rtl/sat_clamp_pkg.sv
// Package: shared types for the saturating clamp stage.
// Assumes destination widths are DATA_W >> k for k = NUM_W-1 .. 0.
package sat_clamp_pkg;

    // Destination width codes; the code order sets the lane order.
    typedef enum logic [1:0] {
        EW_8  = 2'd0,
        EW_16 = 2'd1,
        EW_32 = 2'd2,
        EW_64 = 2'd3
    } ewidth_e;

    // Out-of-range indications for one destination width.
    typedef struct packed {
        logic s_over;
        logic s_under;
        logic u_over;
        logic u_under;
    } range_flags_t;

endpackage

// File: rtl/sat_clamp_lanes.sv
// Module: sat_clamp_lanes
// Evaluates the wide value against every supported destination width in
// parallel and muxes out the lane picked by the width code.
// Assumes the wide value is two's complement, DATA_W data bits plus a sign
// (guard) bit, and that lane i has width DATA_W >> (NUM_W-1-i).
module sat_clamp_lanes
    import sat_clamp_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int NUM_W  = 4,
    localparam int SEL_W = $clog2(NUM_W)
) (
    input  logic [DATA_W:0]   wide,
    input  logic [SEL_W-1:0]  sel,
    output range_flags_t      flags,
    output logic [DATA_W-1:0] wrap_s,
    output logic [DATA_W-1:0] wrap_u,
    output logic [DATA_W-1:0] smax,
    output logic [DATA_W-1:0] smin,
    output logic [DATA_W-1:0] umax
);

    range_flags_t              lane_flags  [NUM_W];
    logic [DATA_W-1:0]         lane_wrap_s [NUM_W];
    logic [DATA_W-1:0]         lane_wrap_u [NUM_W];
    logic [DATA_W-1:0]         lane_smax   [NUM_W];
    logic [DATA_W-1:0]         lane_umax   [NUM_W];

    logic sign_bit;
    assign sign_bit = wide[DATA_W];

    for (genvar i = 0; i < NUM_W; i++) begin : g_lane
        localparam int LW = DATA_W >> (NUM_W - 1 - i);
        localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};
        localparam logic [DATA_W-1:0] LOW_MASK =
            (LW >= DATA_W) ? {DATA_W{1'b1}} : ((ONE << LW) - ONE);
        localparam logic [DATA_W-1:0] HI_MASK = ~(LOW_MASK >> 1);

        logic [DATA_W-1:0] hi_s;
        logic              hi_u_any;

        // Range tests: signed needs bits LW-1 and up to equal the sign bit.
        always_comb begin
            hi_s     = wide[DATA_W-1:0] & HI_MASK;
            hi_u_any = |(wide[DATA_W-1:0] & ~LOW_MASK);
            lane_flags[i].s_over  = !sign_bit && (hi_s != '0);
            lane_flags[i].s_under = sign_bit && (hi_s != HI_MASK);
            lane_flags[i].u_over  = !sign_bit && hi_u_any;
            lane_flags[i].u_under = sign_bit;
        end

        // Wrapped values and bounds for this lane.
        always_comb begin
            lane_wrap_u[i] = wide[DATA_W-1:0] & LOW_MASK;
            lane_wrap_s[i] = lane_wrap_u[i] | (wide[LW-1] ? ~LOW_MASK : '0);
            lane_umax[i]   = LOW_MASK;
            lane_smax[i]   = LOW_MASK >> 1;
        end
    end

    // Lane select by destination width code.
    always_comb begin
        flags  = lane_flags[sel];
        wrap_s = lane_wrap_s[sel];
        wrap_u = lane_wrap_u[sel];
        smax   = lane_smax[sel];
        smin   = ~lane_smax[sel];
        umax   = lane_umax[sel];
    end

endmodule

// File: rtl/sat_clamp_pick.sv
// Module: sat_clamp_pick
// Chooses the final narrowed value from the selected lane: clamp to a bound
// when saturating and out of range, otherwise the wrapped value.
// Assumes the lane outputs already carry the 64-bit extension.
module sat_clamp_pick
    import sat_clamp_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              is_signed,
    input  logic              sat_en,
    input  range_flags_t      flags,
    input  logic [DATA_W-1:0] wrap_s,
    input  logic [DATA_W-1:0] wrap_u,
    input  logic [DATA_W-1:0] smax,
    input  logic [DATA_W-1:0] smin,
    input  logic [DATA_W-1:0] umax,
    output logic [DATA_W-1:0] res,
    output logic              clamped
);

    // Final value and clamp indication.
    always_comb begin
        res     = is_signed ? wrap_s : wrap_u;
        clamped = 1'b0;
        if (sat_en) begin
            if (is_signed) begin
                if (flags.s_over) begin
                    res = smax;  clamped = 1'b1;
                end else if (flags.s_under) begin
                    res = smin;  clamped = 1'b1;
                end
            end else begin
                if (flags.u_over) begin
                    res = umax;  clamped = 1'b1;
                end else if (flags.u_under) begin
                    res = '0;    clamped = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/sat_clamp_stage.sv
// Module: sat_clamp_stage (top)
// One registered stage narrowing a wide integer result to a destination
// element width with optional signed/unsigned saturation, a per-element
// overflow flag and an illegal-combination flag.
// Assumes DATA_W = 64 with NUM_W = 4 widths (8/16/32/64); reset is
// synchronous and active low.
module sat_clamp_stage
    import sat_clamp_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int NUM_W  = 4,
    localparam int SEL_W = $clog2(NUM_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W:0]   in_wide,
    input  logic [SEL_W-1:0]  in_ewidth,
    input  logic              in_signed,
    input  logic              in_sat_en,
    input  logic              in_rc,
    input  logic              in_oe,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_res,
    output logic              out_ov,
    output logic              out_illegal
);

    range_flags_t      flags;
    logic [DATA_W-1:0] wrap_s, wrap_u, smax, smin, umax;
    logic [DATA_W-1:0] nxt_res;
    logic              clamped;

    sat_clamp_lanes #(.DATA_W(DATA_W), .NUM_W(NUM_W)) u_lanes (
        .wide   (in_wide),
        .sel    (in_ewidth),
        .flags  (flags),
        .wrap_s (wrap_s),
        .wrap_u (wrap_u),
        .smax   (smax),
        .smin   (smin),
        .umax   (umax)
    );

    sat_clamp_pick #(.DATA_W(DATA_W)) u_pick (
        .is_signed (in_signed),
        .sat_en    (in_sat_en),
        .flags     (flags),
        .wrap_s    (wrap_s),
        .wrap_u    (wrap_u),
        .smax      (smax),
        .smin      (smin),
        .umax      (umax),
        .res       (nxt_res),
        .clamped   (clamped)
    );

    // Output register: capture on valid, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_res     <= '0;
            out_ov      <= 1'b0;
            out_illegal <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_res     <= nxt_res;
                out_ov      <= in_rc && clamped;
                out_illegal <= in_sat_en && in_oe;
            end
        end
    end

    // Marks that the previous edge was outside reset, for $past checks.
    logic armed;
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    a_r8_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (out_valid == $past(in_valid)));

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !$past(in_valid)) |-> ($stable(out_res) && $stable(out_ov)
                                         && $stable(out_illegal)));

    a_r7_illegal: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(in_valid)) |->
            (out_illegal == ($past(in_sat_en) && $past(in_oe))));

    a_r5_ov_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(in_valid) && out_ov) |->
            ($past(in_rc) && $past(in_sat_en)));

    a_r1_unsigned_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(in_valid && in_sat_en && !in_signed && (in_ewidth == EW_8)))
            |-> (out_res[DATA_W-1:8] == '0));

    a_r2_signed_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(in_valid && in_sat_en && in_signed && (in_ewidth == EW_8)))
            |-> ((&out_res[DATA_W-1:7]) || !(|out_res[DATA_W-1:7])));

    a_r6_no_ov_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(in_valid && !in_sat_en)) |-> !out_ov);

endmodule

// File: tb/sat_clamp_stage_tb.sv
module sat_clamp_stage_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [64:0] in_wide;
    logic [1:0]  in_ewidth;
    logic        in_signed, in_sat_en, in_rc, in_oe;
    logic        out_valid;
    logic [63:0] out_res;
    logic        out_ov, out_illegal;

    int total = 0;
    int bad   = 0;

    // model state: what the outputs must show after the next edge
    logic        e_valid = 1'b0;
    logic [63:0] e_res   = '0;
    logic        e_ov    = 1'b0;
    logic        e_ill   = 1'b0;
    string       e_tag   = "R9";

    always #(CLK_PERIOD/2) clk = ~clk;

    sat_clamp_stage u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_wide(in_wide),
        .in_ewidth(in_ewidth), .in_signed(in_signed), .in_sat_en(in_sat_en),
        .in_rc(in_rc), .in_oe(in_oe), .out_valid(out_valid),
        .out_res(out_res), .out_ov(out_ov), .out_illegal(out_illegal)
    );

    task automatic check_now();
        total++;
        if (out_valid !== e_valid || out_res !== e_res ||
            out_ov !== e_ov || out_illegal !== e_ill) begin
            bad++;
            $display("FAIL %s: got v=%0b res=%h ov=%0b ill=%0b exp v=%0b res=%h ov=%0b ill=%0b",
                     e_tag, out_valid, out_res, out_ov, out_illegal,
                     e_valid, e_res, e_ov, e_ill);
        end
    endtask

    // behavioural reference for one element
    task automatic model(input logic [64:0] x, input logic [1:0] ew,
                         input logic sg, input logic sat, input logic rc,
                         input logic oe);
        logic signed [66:0] v, one, umax, smax, smin, c;
        logic [63:0] mask, wr;
        int w;
        logic hit;
        w    = 8 << ew;
        one  = 67'sd1;
        v    = $signed({{2{x[64]}}, x});
        umax = (one <<< w) - one;
        smax = (one <<< (w - 1)) - one;
        smin = -(one <<< (w - 1));
        mask = (w == 64) ? {64{1'b1}} : ((64'd1 << w) - 64'd1);
        wr   = x[63:0] & mask;
        if (sg && x[w-1]) wr = wr | ~mask;
        hit = 1'b0;
        c   = v;
        if (sat) begin
            if (sg) begin
                if (v > smax) begin c = smax; hit = 1'b1; end
                else if (v < smin) begin c = smin; hit = 1'b1; end
            end else begin
                if (v > umax) begin c = umax; hit = 1'b1; end
                else if (v < 0) begin c = 0; hit = 1'b1; end
            end
            e_res = c[63:0];
        end else begin
            e_res = wr;
        end
        e_ov  = rc && hit;
        e_ill = sat && oe;
    endtask

    // one cycle: check outputs of the previous element, then drive a new one
    task automatic step(input logic vld, input logic [64:0] x, input logic [1:0] ew,
                        input logic sg, input logic sat, input logic rc,
                        input logic oe, input string tag);
        @(negedge clk);
        check_now();
        in_valid = vld; in_wide = x; in_ewidth = ew; in_signed = sg;
        in_sat_en = sat; in_rc = rc; in_oe = oe;
        e_valid = vld;
        e_tag   = tag;
        if (vld) model(x, ew, sg, sat, rc, oe);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b1; in_wide = '1; in_ewidth = 2'd0;
        in_signed = 1'b1; in_sat_en = 1'b1; in_rc = 1'b1; in_oe = 1'b1;
        repeat (3) @(negedge clk);
        check_now();                              // R9 reset clears all
        in_valid = 1'b0;
        rst_n = 1'b1;
        // R1 unsigned clamp
        step(1, 65'd300,  0, 0, 1, 1, 0, "R1");
        step(1, -65'sd5,  0, 0, 1, 1, 0, "R1");
        step(1, 65'd256,  0, 0, 1, 1, 0, "R1");
        step(1, 65'd70000, 1, 0, 1, 1, 0, "R1");
        step(1, {1'b1, 64'd0}, 3, 0, 1, 1, 0, "R1");
        // R2 signed clamp
        step(1, 65'd200,   0, 1, 1, 1, 0, "R2");
        step(1, -65'sd200, 0, 1, 1, 1, 0, "R2");
        step(1, -65'sd129, 0, 1, 1, 1, 0, "R2");
        step(1, 65'd40000, 1, 1, 1, 1, 0, "R2");
        step(1, 65'h1_0000_0000, 2, 1, 1, 1, 0, "R2");
        step(1, {1'b0, 64'hFFFF_FFFF_FFFF_FFFF}, 3, 1, 1, 1, 0, "R2");
        step(1, {1'b1, 64'd0}, 3, 1, 1, 1, 0, "R2");
        // R3 values on the bounds pass unchanged
        step(1, -65'sd128, 0, 1, 1, 1, 0, "R3");
        step(1, 65'd127,   0, 1, 1, 1, 0, "R3");
        step(1, 65'd255,   0, 0, 1, 1, 0, "R3");
        step(1, 65'd0,     0, 0, 1, 1, 0, "R3");
        step(1, {1'b0, 64'hFFFF_FFFF_FFFF_FFFF}, 3, 0, 1, 1, 0, "R3");
        // R4 same value through each width code
        for (int k = 0; k < 4; k++) step(1, 65'h1_8000_8080, k[1:0], 1, 1, 1, 0, "R4");
        // R5 overflow flag gating and no carry-over between elements
        step(1, 65'd300, 0, 0, 1, 0, 0, "R5");
        step(1, 65'd300, 0, 0, 1, 1, 0, "R5");
        step(1, 65'd10,  0, 0, 1, 1, 0, "R5");
        // R6 wrap when saturation off
        step(1, 65'd300,  0, 0, 0, 1, 0, "R6");
        step(1, 65'h1F0,  0, 1, 0, 1, 0, "R6");
        step(1, 65'h1_2345_8000, 1, 1, 0, 1, 0, "R6");
        // R7 illegal combination
        step(1, 65'd300, 0, 0, 1, 0, 1, "R7");
        step(1, 65'd300, 0, 0, 0, 1, 1, "R7");
        step(1, 65'd5,   0, 1, 1, 1, 1, "R7");
        // R8 hold with junk on the inputs while invalid
        step(0, '1, 3, 1, 1, 1, 1, "R8");
        step(0, '0, 0, 0, 0, 0, 0, "R8");
        // random mix, R5 and all other rules via the model
        for (int n = 0; n < 400; n++) begin
            logic [64:0] x;
            logic [1:0]  ew;
            ew = 2'($urandom_range(0, 3));
            case ($urandom_range(0, 2))
                0: x = {$urandom, $urandom, $urandom};
                1: x = 65'($signed($urandom_range(0, 600)) - 300);
                default: x = {{33{1'b0}}, $urandom} << (8 * ew);
            endcase
            step(1'($urandom_range(0, 3) != 0), x, ew, 1'($urandom), 1'($urandom),
                 1'($urandom), 1'($urandom), "R5");
        end
        step(0, '0, 0, 0, 0, 0, 0, "R8");
        @(negedge clk);
        check_now();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule